// File: doc/BRIEF.md
# Buffered Full-Duplex SPI Master

This block is an SPI master that buffers outgoing and incoming words in two 16-entry FIFOs. Software or a neighbouring block fills the transmit FIFO and drains the receive FIFO. Every word shifted out on MOSI brings one word back from MISO. If only receive data is wanted, the caller still queues a dummy transmit word.

Bring-up is staged by four enables. The serial-clock enable starts the baud generator. The frame enable arms the slave-select logic. The transmit and receive enables let words move. Even with all four set, SCK and the select line stay quiet until a word sits in the transmit FIFO. Consecutive queued words share one select frame.

Two level flags let the caller pace itself: a transmit request for refilling and a receive request for draining. A combined empty flag reports that the FIFO is drained and the shifter has stopped. There is a sticky access-error bit, and an optional sticky interrupt for running dry while the transmitter is still enabled. Separate soft-reset strobes clear each direction.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the outputs are as follows. spiSsN is 1. spiSck and spiMosi are 0. txEmpty and txReq are 1. rxReq, errFlag and underIrq are 0.
- R2: Inside a frame, each SCK half period, and the gap from the select falling to the first SCK rise, lasts (cfgPrescale+1) * 2^cfgDivSel clock cycles.
- R3: A frame starts only when all of the following hold: cfgSckEn, cfgFrameEn and cfgTxEn are 1, and the transmit FIFO holds a word. Until then spiSsN stays 1 and SCK does not toggle. While spiSsN is 1, spiSck is 0.
- R4: SPI mode 0 is used, MSB first. A word is cfgWordLen+1 bits long, and values of cfgWordLen below 7 give 8 bits. MOSI changes only while SCK is low. MISO is sampled when SCK rises.
- R5: Each transmitted word yields exactly one received word. The received word holds the bits sampled from MISO. It is stored in the receive FIFO only when cfgRxEn is 1.
- R6: Words already queued go out back to back under one select frame (one falling edge of spiSsN). spiSsN returns to 1 after the last word.
- R7: Clearing cfgTxEn during a word lets that word complete. No further word then starts, and spiSsN returns to 1.
- R8: txReq is 1 when the transmit fill level is at most cfgTxThresh. rxReq is 1 when the receive fill level exceeds cfgRxThresh.
- R9: txEmpty is 1 only when the transmit FIFO is empty and no word is being shifted.
- R10: rxData updates on the cycle after a rxRead strobe. All three of the following set errFlag:
  - reading an empty receive FIFO, which leaves rxData unchanged;
  - writing a full transmit FIFO, whose data is dropped;
  - a received word arriving at a full receive FIFO.
  errFlag stays set until rxRst.
- R11: Suppose a word finishes while cfgTxEn is 1 and the transmit FIFO is empty. If cfgUnderIntEn is 1, underIrq is set. underIrq stays set until txRst.
- R12: txRst does three things: it empties the transmit FIFO, aborts any word with spiSsN at 1 and spiSck at 0 on the next cycle, and clears underIrq. Clearing cfgFrameEn also aborts the frame. rxRst empties the receive FIFO and clears errFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSckEn | input | 1 | Runs the baud generator |
| cfgFrameEn | input | 1 | Arms framing; low aborts a frame |
| cfgTxEn | input | 1 | Allows new words to start |
| cfgRxEn | input | 1 | Allows received words into the FIFO |
| cfgPrescale | input | 5 | Prescaler, divide by value+1 |
| cfgDivSel | input | 3 | Divider, multiply by 2^value |
| cfgWordLen | input | 4 | Word length minus one (minimum 7) |
| cfgTxThresh | input | 4 | Transmit request level |
| cfgRxThresh | input | 4 | Receive request level |
| cfgUnderIntEn | input | 1 | Enables the underflow interrupt |
| txRst | input | 1 | Transmit-side soft reset |
| rxRst | input | 1 | Receive-side soft reset |
| txWrite | input | 1 | Push strobe for txData |
| txData | input | 16 | Word to transmit, right aligned |
| rxRead | input | 1 | Pop strobe for the receive FIFO |
| rxData | output | 16 | Last word popped, right aligned |
| txReq | output | 1 | Transmit FIFO needs data |
| rxReq | output | 1 | Receive FIFO has data to take |
| txEmpty | output | 1 | Transmit FIFO empty and shifter idle |
| errFlag | output | 1 | Sticky access error |
| underIrq | output | 1 | Sticky underflow interrupt |
| spiSck | output | 1 | Serial clock |
| spiSsN | output | 1 | Slave select, active low |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |

## Verification
A wrong baud count or phase bit changes the spacing of the SCK edges within one half period, so the measured edge-to-edge times expose it in the first frame. A bit counter that is off by one shows up at the end of that same word: the slave model captures a misaligned word, or the select frame closes early. Faults in the FIFO pointers or level counts show up when the request flags are sampled right after a few writes. They also show up when words read back out of order. Faults in the sticky error and interrupt bits show up when these bits are observed across several idle cycles and across the soft-reset strobes.

// File: rtl/spi_fifo_pkg.sv
`timescale 1ns/1ps
package spi_fifo_pkg;
  // Per-cycle strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic loadWord;   // pop tx FIFO head into the shifter
    logic sampleBit;  // capture MISO (SCK rising)
    logic shiftBit;   // advance MOSI (SCK falling)
    logic wordDone;   // last falling edge of a word
    logic txStarved;  // word finished with tx enabled and FIFO empty
    logic abort;      // drop the word in flight
  } spiStrobe_t;
endpackage

// File: rtl/spi_fifo.sv
`timescale 1ns/1ps
module spi_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_ctrl.sv
`timescale 1ns/1ps
module spi_ctrl import spi_fifo_pkg::*; #(
  parameter int PRE_W = 5,
  parameter int DIV_W = 3,
  parameter int LEN_W = 4,
  localparam int CNT_W = PRE_W + (1 << DIV_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckEn,
  input  logic             frameEn,
  input  logic             txEn,
  input  logic [PRE_W-1:0] prescale,
  input  logic [DIV_W-1:0] divSel,
  input  logic [LEN_W-1:0] lenM1,
  input  logic             baudRst,
  input  logic             abortIn,
  input  logic             txFifoEmpty,
  output spiStrobe_t       strobe,
  output logic             sck,
  output logic             busy
);
  logic [CNT_W-1:0] baudCnt, baudLimit;
  logic [LEN_W-1:0] bitCnt;
  logic             tick, canStart, lastBit;

  // Half-period length: (prescale+1) << divSel clocks.
  assign baudLimit = (CNT_W'(prescale) + CNT_W'(1)) << divSel;
  assign tick      = sckEn && !baudRst && (baudCnt == baudLimit - CNT_W'(1));
  assign canStart  = sckEn && frameEn && txEn && !txFifoEmpty;
  assign lastBit   = (bitCnt == lenM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        baudCnt <= '0;
    else if (baudRst || !sckEn || tick) baudCnt <= '0;
    else                              baudCnt <= baudCnt + CNT_W'(1);
  end

  always_comb begin
    strobe       = '0;
    strobe.abort = abortIn;
    if (tick && !abortIn) begin
      if (!busy) begin
        strobe.loadWord = canStart;
      end else if (!sck) begin
        strobe.sampleBit = 1'b1;
      end else if (lastBit) begin
        strobe.wordDone  = 1'b1;
        strobe.loadWord  = canStart;
        strobe.txStarved = txEn && txFifoEmpty;
      end else begin
        strobe.shiftBit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sck    <= 1'b0;
      bitCnt <= '0;
    end else if (abortIn) begin
      busy   <= 1'b0;
      sck    <= 1'b0;
      bitCnt <= '0;
    end else if (tick) begin
      if (!busy) begin
        busy   <= canStart;
        sck    <= 1'b0;
        bitCnt <= '0;
      end else if (!sck) begin
        sck <= 1'b1;
      end else begin
        sck <= 1'b0;
        if (lastBit) begin
          bitCnt <= '0;
          busy   <= canStart;
        end else begin
          bitCnt <= bitCnt + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_dpath.sv
`timescale 1ns/1ps
module spi_dpath import spi_fifo_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 4,
  parameter int THR_W  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        strobe,
  input  logic              busy,
  input  logic [LEN_W-1:0]  lenM1,
  input  logic              rxEn,
  input  logic              txRst,
  input  logic              rxRst,
  input  logic [THR_W-1:0]  txThresh,
  input  logic [THR_W-1:0]  rxThresh,
  input  logic              underIntEn,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData,
  output logic              txReq,
  output logic              rxReq,
  output logic              txEmpty,
  output logic              txFifoEmpty,
  output logic              errFlag,
  output logic              underIrq
);
  logic [DATA_W-1:0] txHead, rxHead, txShift, rxShift, lenMask, rxWord;
  logic [CNT_W-1:0]  txCount, rxCount;
  logic              txFull, rxFull, rxFifoEmpty, rxPush, rxOverflow;
  logic              txWrFull, rxRdEmpty;

  spi_fifo #(.W(DATA_W), .DEPTH(DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .clr(txRst), .push(txWrite), .pop(strobe.loadWord),
    .din(txData), .head(txHead), .count(txCount), .full(txFull), .empty(txFifoEmpty));

  spi_fifo #(.W(DATA_W), .DEPTH(DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .clr(rxRst), .push(rxPush), .pop(rxRead),
    .din(rxWord), .head(rxHead), .count(rxCount), .full(rxFull), .empty(rxFifoEmpty));

  always_comb begin
    for (int i = 0; i < DATA_W; i++) lenMask[i] = (i <= int'(lenM1));
  end

  assign rxWord     = rxShift & lenMask;
  assign rxPush     = strobe.wordDone && rxEn && !rxRst;
  assign rxOverflow = rxPush && rxFull;
  assign txWrFull   = txWrite && txFull && !txRst;
  assign rxRdEmpty  = rxRead && rxFifoEmpty;
  assign mosi       = txShift[DATA_W-1];

  assign txReq   = (txCount <= CNT_W'(txThresh));
  assign rxReq   = (rxCount > CNT_W'(rxThresh));
  assign txEmpty = txFifoEmpty && !busy;

  // Transmit shifter: word left-aligned so MSB of the active length leads.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  txShift <= '0;
    else if (strobe.abort)      txShift <= '0;
    else if (strobe.loadWord)   txShift <= txHead << (LEN_W'(DATA_W - 1) - lenM1);
    else if (strobe.wordDone)   txShift <= '0;
    else if (strobe.shiftBit)   txShift <= txShift << 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rxShift <= '0;
    else if (strobe.abort)      rxShift <= '0;
    else if (strobe.sampleBit)  rxShift <= {rxShift[DATA_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          rxData <= '0;
    else if (rxRead && !rxFifoEmpty)    rxData <= rxHead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     errFlag <= 1'b0;
    else if (rxRst)                                errFlag <= 1'b0;
    else if (txWrFull || rxRdEmpty || rxOverflow)  errFlag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   underIrq <= 1'b0;
    else if (txRst)                              underIrq <= 1'b0;
    else if (strobe.txStarved && underIntEn)     underIrq <= 1'b1;
  end
endmodule

// File: rtl/spi_fifo_master.sv
`timescale 1ns/1ps
module spi_fifo_master import spi_fifo_pkg::*; #(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int PRE_W      = 5,
  parameter int DIV_W      = 3,
  parameter int MIN_BITS   = 8,
  localparam int LEN_W     = $clog2(DATA_W),
  localparam int THR_W     = $clog2(FIFO_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSckEn,
  input  logic              cfgFrameEn,
  input  logic              cfgTxEn,
  input  logic              cfgRxEn,
  input  logic [PRE_W-1:0]  cfgPrescale,
  input  logic [DIV_W-1:0]  cfgDivSel,
  input  logic [LEN_W-1:0]  cfgWordLen,
  input  logic [THR_W-1:0]  cfgTxThresh,
  input  logic [THR_W-1:0]  cfgRxThresh,
  input  logic              cfgUnderIntEn,
  input  logic              txRst,
  input  logic              rxRst,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxData,
  output logic              txReq,
  output logic              rxReq,
  output logic              txEmpty,
  output logic              errFlag,
  output logic              underIrq,
  output logic              spiSck,
  output logic              spiSsN,
  output logic              spiMosi,
  input  logic              spiMiso
);
  spiStrobe_t       strobe;
  logic             busy, txFifoEmpty;
  logic [LEN_W-1:0] lenM1;

  assign lenM1  = (cfgWordLen < LEN_W'(MIN_BITS - 1)) ? LEN_W'(MIN_BITS - 1) : cfgWordLen;
  assign spiSsN = !busy;

  spi_ctrl #(.PRE_W(PRE_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sckEn(cfgSckEn), .frameEn(cfgFrameEn), .txEn(cfgTxEn),
    .prescale(cfgPrescale), .divSel(cfgDivSel), .lenM1(lenM1),
    .baudRst(txRst || rxRst), .abortIn(txRst || !cfgFrameEn),
    .txFifoEmpty(txFifoEmpty), .strobe(strobe), .sck(spiSck), .busy(busy));

  spi_dpath #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .LEN_W(LEN_W), .THR_W(THR_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy), .lenM1(lenM1), .rxEn(cfgRxEn),
    .txRst(txRst), .rxRst(rxRst), .txThresh(cfgTxThresh), .rxThresh(cfgRxThresh),
    .underIntEn(cfgUnderIntEn), .txWrite(txWrite), .txData(txData), .rxRead(rxRead),
    .miso(spiMiso), .mosi(spiMosi), .rxData(rxData), .txReq(txReq), .rxReq(rxReq),
    .txEmpty(txEmpty), .txFifoEmpty(txFifoEmpty), .errFlag(errFlag), .underIrq(underIrq));
endmodule

// File: rtl/spi_fifo_master_chk.sv
`timescale 1ns/1ps
module spi_fifo_master_chk (
  input logic clk,
  input logic rstN,
  input logic cfgSckEn,
  input logic cfgFrameEn,
  input logic cfgTxEn,
  input logic cfgUnderIntEn,
  input logic txRst,
  input logic rxRst,
  input logic txEmpty,
  input logic errFlag,
  input logic underIrq,
  input logic spiSck,
  input logic spiSsN,
  input logic spiMosi
);
  AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    spiSsN |-> !spiSck); // R3
  AST_FRAME_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiSsN) |-> ($past(cfgSckEn) && $past(cfgFrameEn) && $past(cfgTxEn))); // R3
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    spiSck |-> $stable(spiMosi)); // R4
  AST_EMPTY_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> spiSsN); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(errFlag) && !$past(rxRst)) |-> errFlag); // R10
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underIrq) |-> $past(cfgUnderIntEn)); // R11
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(underIrq) && !$past(txRst)) |-> underIrq); // R11
endmodule

bind spi_fifo_master spi_fifo_master_chk uChk (
  .clk(clk), .rstN(rstN), .cfgSckEn(cfgSckEn), .cfgFrameEn(cfgFrameEn), .cfgTxEn(cfgTxEn),
  .cfgUnderIntEn(cfgUnderIntEn), .txRst(txRst), .rxRst(rxRst), .txEmpty(txEmpty),
  .errFlag(errFlag), .underIrq(underIrq), .spiSck(spiSck), .spiSsN(spiSsN), .spiMosi(spiMosi));

// File: tb/sim_spi_fifo_master.sv
`timescale 1ns/1ps
module sim_spi_fifo_master;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgSckEn = 0, cfgFrameEn = 0, cfgTxEn = 0, cfgRxEn = 0, cfgUnderIntEn = 0;
  logic [4:0] cfgPrescale = '0;
  logic [2:0] cfgDivSel = '0;
  logic [3:0] cfgWordLen = '0, cfgTxThresh = '0, cfgRxThresh = '0;
  logic txRst = 0, rxRst = 0, txWrite = 0, rxRead = 0;
  logic [15:0] txData = '0, rxData;
  logic txReq, rxReq, txEmpty, errFlag, underIrq, spiSck, spiSsN, spiMosi, spiMiso;

  always #2 clk = ~clk;

  spi_fifo_master u0 (.*);

  int nChecks = 0, nFails = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] maskOf(input int bits);
    return (bits >= 16) ? 16'hFFFF : 16'((32'd1 << bits) - 1);
  endfunction
  function automatic int effBits(input int lenM1);
    return (lenM1 < 7) ? 8 : lenM1 + 1;
  endfunction

  // Slave model: captures MOSI on SCK rise, presents next MISO bit after it.
  int sBits = 8, sIdx = 0, frameCnt = 0, sckEdges = 0;
  logic [15:0] sTx = '0, sCap = '0;
  logic [15:0] slvQ[$], mosiSeen[$];
  longint lastEdge = 0, minHalf = 0, maxHalf = 0;
  assign spiMiso = sTx[15];

  function automatic logic [15:0] nextSlv();
    logic [15:0] w;
    if (slvQ.size() == 0) return '0;
    w = slvQ.pop_front();
    return 16'(w << (16 - sBits));
  endfunction

  always @(negedge spiSsN) begin
    frameCnt++; sIdx = 0; sCap = '0; sTx = nextSlv(); lastEdge = $time;
  end
  always @(spiSck) begin
    longint d;
    sckEdges++;
    if (!spiSsN) begin
      d = $time - lastEdge;
      if (d < minHalf) minHalf = d;
      if (d > maxHalf) maxHalf = d;
      lastEdge = $time;
    end
  end
  always @(posedge spiSck) begin
    sCap = {sCap[14:0], spiMosi};
    sIdx++;
    if (sIdx == sBits) begin
      mosiSeen.push_back(sCap & maskOf(sBits));
      sIdx = 0; sCap = '0; sTx = nextSlv();
    end else sTx = sTx << 1;
  end

  task automatic printSummary();
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      printSummary();
      $finish;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic writeWord(input logic [15:0] d);
    @(negedge clk); txWrite = 1; txData = d;
    @(negedge clk); txWrite = 0;
  endtask
  task automatic readRx(output logic [15:0] v);
    @(negedge clk); rxRead = 1;
    @(negedge clk); rxRead = 0; v = rxData;
  endtask
  task automatic pulseTxRst();
    @(negedge clk); txRst = 1; @(negedge clk); txRst = 0;
  endtask
  task automatic pulseRxRst();
    @(negedge clk); rxRst = 1; @(negedge clk); rxRst = 0;
  endtask
  task automatic waitIdle();
    int k = 0;
    do begin @(negedge clk); k++; end while (!(txEmpty && spiSsN) && k < 20000);
  endtask
  task automatic waitFrame();
    int k = 0;
    while (spiSsN && k < 20000) begin @(negedge clk); k++; end
  endtask
  task automatic allOff();
    @(negedge clk);
    cfgTxEn = 0; cfgRxEn = 0; cfgFrameEn = 0; cfgSckEn = 0; cfgUnderIntEn = 0;
  endtask
  task automatic setup(input int pre, input int dv, input int len);
    @(negedge clk);
    cfgPrescale = 5'(pre); cfgDivSel = 3'(dv); cfgWordLen = 4'(len);
    sBits = effBits(len); slvQ.delete(); mosiSeen.delete();
    minHalf = 64'd1 << 40; maxHalf = 0;
  endtask
  task automatic enableStaged(input logic rxOn);
    @(negedge clk); cfgSckEn = 1;
    @(negedge clk); cfgFrameEn = 1;
    @(negedge clk); cfgTxEn = 1; cfgRxEn = rxOn;
  endtask

  logic [15:0] txW[8], sW[8], v, lastRead;

  task automatic runRandom(input int n, input int pre, input int dv, input int len);
    int f0;
    setup(pre, dv, len);
    cfgRxThresh = 4'(n - 1);
    for (int i = 0; i < n; i++) begin
      txW[i] = 16'($urandom); sW[i] = 16'($urandom); slvQ.push_back(sW[i]);
    end
    f0 = frameCnt;
    enableStaged(1'b1);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin txWrite = 1; txData = txW[i]; @(negedge clk); end
    txWrite = 0;
    waitIdle();
    chk("R5 words shifted", mosiSeen.size(), n);
    for (int i = 0; i < n && i < mosiSeen.size(); i++)
      chk("R4 MOSI word MSB first", mosiSeen[i], txW[i] & maskOf(sBits));
    chk("R6 one frame for queued words", frameCnt - f0, 1);
    chk("R6 select released", spiSsN, 1);
    chk("R2 min half period", 32'(minHalf), ((pre + 1) << dv) * 4);
    chk("R2 max half period", 32'(maxHalf), ((pre + 1) << dv) * 4);
    chk("R8 rxReq above threshold", rxReq, 1);
    for (int i = 0; i < n; i++) begin
      readRx(v);
      chk("R5 MISO word received", v, sW[i] & maskOf(sBits));
      lastRead = v;
    end
    chk("R8 rxReq cleared", rxReq, 0);
    chk("R10 no error on legal use", errFlag, 0);
    chk("R11 no irq when disabled", underIrq, 0);
    allOff();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cycles(4);
    chk("R1 ssN", spiSsN, 1);
    chk("R1 sck", spiSck, 0);
    chk("R1 mosi", spiMosi, 0);
    @(negedge clk); rstN = 1;
    cycles(2);
    chk("R1 ssN", spiSsN, 1);
    chk("R1 sck", spiSck, 0);
    chk("R1 mosi", spiMosi, 0);
    chk("R1 txEmpty", txEmpty, 1);
    chk("R1 txReq", txReq, 1);
    chk("R1 rxReq", rxReq, 0);
    chk("R1 errFlag", errFlag, 0);
    chk("R1 underIrq", underIrq, 0);

    // Directed corners first, then random mix.
    runRandom(1, 0, 0, 7);
    runRandom(3, 0, 0, 15);
    runRandom(2, 1, 1, 3);   // length clamps to 8 bits
    for (int t = 0; t < 10; t++)
      runRandom($urandom_range(1, 6), $urandom_range(0, 3), $urandom_range(0, 2),
                $urandom_range(0, 15));

    // R3: no start without tx enable, then without clock enable.
    setup(0, 1, 7);
    slvQ.push_back(16'h5A);
    @(negedge clk); cfgSckEn = 1; cfgFrameEn = 1; cfgRxEn = 1;
    writeWord(16'hC3);
    sckEdges = 0;
    cycles(100);
    chk("R3 no frame without tx enable", spiSsN, 1);
    chk("R3 no SCK without tx enable", sckEdges, 0);
    chk("R9 txEmpty low with queued word", txEmpty, 0);
    @(negedge clk); cfgSckEn = 0; cfgTxEn = 1;
    cycles(100);
    chk("R3 no frame without clock enable", spiSsN, 1);
    chk("R3 no SCK without clock enable", sckEdges, 0);
    @(negedge clk); cfgSckEn = 1;
    waitIdle();
    chk("R3 word goes once enabled", mosiSeen.size(), 1);
    readRx(v);
    chk("R5 received after enable", v, 16'h5A);
    lastRead = v;
    allOff();

    // R10: empty read keeps data and sets error, sticky until rxRst.
    readRx(v);
    chk("R10 empty read keeps rxData", v, lastRead);
    chk("R10 empty read sets error", errFlag, 1);
    cycles(5);
    chk("R10 error sticky", errFlag, 1);
    pulseRxRst();
    chk("R12 rxRst clears error", errFlag, 0);

    // R8 tx threshold, R10 full write, R12 txRst.
    @(negedge clk); cfgTxThresh = 4'd2;
    writeWord(16'h1); writeWord(16'h2);
    chk("R8 txReq at threshold", txReq, 1);
    writeWord(16'h3);
    chk("R8 txReq above threshold", txReq, 0);
    for (int i = 0; i < 13; i++) writeWord(16'(i));
    chk("R10 no error at exactly full", errFlag, 0);
    writeWord(16'hFFFF);
    chk("R10 write to full sets error", errFlag, 1);
    pulseTxRst();
    chk("R12 txRst empties FIFO", txEmpty, 1);
    chk("R12 txRst restores txReq", txReq, 1);
    chk("R12 txRst leaves error", errFlag, 1);
    pulseRxRst();
    @(negedge clk); cfgTxThresh = 4'd0;

    // R5: receive disabled drops words.
    setup(0, 0, 7);
    cfgRxThresh = 4'd0;
    enableStaged(1'b0);
    writeWord(16'h11); writeWord(16'h22);
    waitIdle();
    chk("R5 words still shifted", mosiSeen.size(), 2);
    chk("R5 rx disabled stores nothing", rxReq, 0);
    readRx(v);
    chk("R5 rx FIFO empty after disabled rx", errFlag, 1);
    pulseRxRst();
    allOff();

    // R7: clear tx enable mid-word.
    setup(3, 1, 7);
    slvQ.push_back(16'hA5);
    enableStaged(1'b1);
    writeWord(16'h96); writeWord(16'h33); writeWord(16'h44);
    waitFrame();
    cycles(10);
    @(negedge clk); cfgTxEn = 0;
    waitIdle();
    for (int k = 0; k < 400 && !spiSsN; k++) @(negedge clk);
    chk("R7 select released", spiSsN, 1);
    chk("R7 word in flight completed", mosiSeen.size(), 1);
    if (mosiSeen.size() > 0) chk("R7 word value", mosiSeen[0], 16'h96);
    cycles(300);
    chk("R7 no new word started", mosiSeen.size(), 1);
    chk("R9 txEmpty low with words left", txEmpty, 0);
    readRx(v);
    chk("R7 completed word received", v, 16'hA5);
    pulseTxRst();
    chk("R12 txRst empties leftovers", txEmpty, 1);
    allOff();

    // R11: underflow interrupt.
    setup(0, 0, 7);
    @(negedge clk); cfgUnderIntEn = 1;
    enableStaged(1'b1);
    writeWord(16'h7E);
    waitIdle();
    cycles(2);
    chk("R11 underflow irq set", underIrq, 1);
    cycles(20);
    chk("R11 irq sticky", underIrq, 1);
    pulseTxRst();
    chk("R12 txRst clears irq", underIrq, 0);
    pulseRxRst();
    allOff();

    // R12: txRst and frame-enable clear abort a word.
    setup(2, 2, 15);
    enableStaged(1'b1);
    writeWord(16'hBEEF);
    waitFrame();
    cycles(7);
    @(negedge clk); txRst = 1;
    @(negedge clk); txRst = 0;
    chk("R12 txRst drops select", spiSsN, 1);
    chk("R12 txRst stops SCK", spiSck, 0);
    chk("R12 txRst empty after abort", txEmpty, 1);
    writeWord(16'h1234);
    waitFrame();
    cycles(7);
    @(negedge clk); cfgFrameEn = 0;
    @(negedge clk);
    chk("R12 frame enable clear drops select", spiSsN, 1);
    chk("R12 frame enable clear stops SCK", spiSck, 0);
    pulseRxRst();
    allOff();

    finished = 1;
    printSummary();
    $finish;
  end
endmodule